// File: doc/BRIEF.md
# ADC Range Detect and Output Coder

This block is the final stage of a calibrated delta-sigma conversion path. Each conversion gives it two values: the sample with offset removed, and the same sample after gain correction. It also receives the two full-scale endpoints captured during calibration. The block compares the offset-removed sample against those endpoints to detect an over-range or under-range condition. The rule for under-range depends on whether the converter runs bipolar or unipolar.

It then forms the output word from the gain-corrected sample, in one of three codes. In bipolar operation the code is two's complement or offset binary. In unipolar operation the code is plain binary. When the sample is out of range, the block replaces the word with the full-scale code at the matching end. Gain-corrected values that do not fit the output word are saturated to those same codes.

The result is registered. It is presented with a one-cycle valid strobe one clock after the input strobe.

Top module: `rc_range_coder`

## Requirements
- R1: `over_flag` is set for a sample when `ofs_val` is greater than `pos_coef`, compared as signed numbers, in both modes. Equality does not set it.
- R2: In unipolar mode (`bipolar`=0), `under_flag` is set exactly when the sign bit of `ofs_val` is 1.
- R3: In bipolar mode (`bipolar`=1), `under_flag` is set exactly when `ofs_val` is less than `neg_coef`, compared as signed numbers. Equality does not set it.
- R4: Both flags depend only on `ofs_val` and the endpoints. `gain_val` never changes a flag.
- R5: In bipolar mode with `twos_sel`=1, an in-range word is the low 24 bits of `gain_val`, in two's complement.
- R6: In bipolar mode with `twos_sel`=0, the word is the two's complement word with bit 23 inverted, which gives offset binary.
- R7: In unipolar mode the word is straight binary. `twos_sel` has no effect on the word.
- R8: On over-range the word is 0x7FFFFF for bipolar two's complement and 0xFFFFFF for the other two codes. On under-range the word is 0x800000 for bipolar two's complement and 0x000000 for the other two codes. If both flags are set, the over-range code wins.
- R9: When the sample is in range but `gain_val` lies outside the word's range, the word saturates to the R8 clamp code at that end. The flags stay clear. The word's range is -2^23..2^23-1 in bipolar mode and 0..2^24-1 in unipolar mode.
- R10: `out_valid` is high for one cycle, in the cycle after each `in_valid` cycle. Word and flags are registered at that edge and hold their values until the next strobe.
- R11: After reset, `out_valid`, `over_flag`, `under_flag` and `code_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| bipolar | input | 1 | 1 = bipolar, 0 = unipolar |
| twos_sel | input | 1 | Bipolar code select: 1 = two's complement, 0 = offset binary |
| ofs_val | input | 28 | Offset-corrected sample, signed |
| gain_val | input | 28 | Gain-corrected sample, signed |
| pos_coef | input | 28 | Positive full-scale endpoint, signed |
| neg_coef | input | 28 | Negative full-scale endpoint, signed |
| code_out | output | 24 | Coded output word |
| over_flag | output | 1 | Over-range detected for the last sample |
| under_flag | output | 1 | Under-range detected for the last sample |
| out_valid | output | 1 | Result strobe |

## Verification
One register stage lies between the inputs and every output. The word, both flags and the valid strobe for a sample applied before clock edge k are therefore due just after edge k. The bench drives each sample on a falling edge and holds `in_valid` for exactly one cycle. It reads all outputs on the next falling edge, half a period after the capturing edge. One cycle later it reads again to confirm that `out_valid` has dropped and that the word has held.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        FMT_BIN  = 2'd0,
        FMT_TWOS = 2'd1,
        FMT_OFFB = 2'd2
    } fmt_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } coder_state_e;
endpackage

// File: rtl/rc_range_detect.sv
module rc_range_detect #(
    parameter int CAL_W = 28
) (
    input  logic                    bipolar,
    input  logic signed [CAL_W-1:0] ofs_val,
    input  logic signed [CAL_W-1:0] pos_coef,
    input  logic signed [CAL_W-1:0] neg_coef,
    output logic                    over,
    output logic                    under
);
    always_comb begin
        over = (ofs_val > pos_coef);
        if (bipolar) begin
            under = (ofs_val < neg_coef);
        end else begin
            under = ofs_val[CAL_W-1];
        end
    end
endmodule

// File: rtl/rc_code_fmt.sv
module rc_code_fmt
    import rc_pkg::*;
#(
    parameter int CAL_W  = 28,
    parameter int DATA_W = 24
) (
    input  fmt_e                     fmt,
    input  logic                     over,
    input  logic                     under,
    input  logic signed [CAL_W-1:0]  gain_val,
    output logic        [DATA_W-1:0] word
);
    localparam int PAD_W = CAL_W - DATA_W;
    localparam logic signed [CAL_W-1:0] BIP_MAX =
        $signed({{(PAD_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
    localparam logic signed [CAL_W-1:0] BIP_MIN = -BIP_MAX - 1;
    localparam logic signed [CAL_W-1:0] UNI_MAX =
        $signed({{PAD_W{1'b0}}, {DATA_W{1'b1}}});
    localparam logic [DATA_W-1:0] TC_TOP = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] TC_BOT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] tc_word;
    logic [DATA_W-1:0] bin_word;

    always_comb begin
        if (over || (!under && gain_val > BIP_MAX)) begin
            tc_word = TC_TOP;
        end else if (under || gain_val < BIP_MIN) begin
            tc_word = TC_BOT;
        end else begin
            tc_word = gain_val[DATA_W-1:0];
        end
    end

    always_comb begin
        if (over || (!under && gain_val > UNI_MAX)) begin
            bin_word = '1;
        end else if (under || gain_val[CAL_W-1]) begin
            bin_word = '0;
        end else begin
            bin_word = gain_val[DATA_W-1:0];
        end
    end

    always_comb begin
        unique case (fmt)
            FMT_TWOS: word = tc_word;
            FMT_OFFB: word = {~tc_word[DATA_W-1], tc_word[DATA_W-2:0]};
            default:  word = bin_word;
        endcase
    end
endmodule

// File: rtl/rc_range_coder.sv
module rc_range_coder
    import rc_pkg::*;
#(
    parameter int CAL_W  = 28,
    parameter int DATA_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    bipolar,
    input  logic                    twos_sel,
    input  logic signed [CAL_W-1:0] ofs_val,
    input  logic signed [CAL_W-1:0] gain_val,
    input  logic signed [CAL_W-1:0] pos_coef,
    input  logic signed [CAL_W-1:0] neg_coef,
    output logic [DATA_W-1:0]       code_out,
    output logic                    over_flag,
    output logic                    under_flag,
    output logic                    out_valid
);
    coder_state_e state_q, state_d;
    fmt_e         fmt;
    logic         over_c, under_c;
    logic [DATA_W-1:0] word_c;

    always_comb begin
        if (!bipolar) begin
            fmt = FMT_BIN;
        end else if (twos_sel) begin
            fmt = FMT_TWOS;
        end else begin
            fmt = FMT_OFFB;
        end
    end

    rc_range_detect #(.CAL_W(CAL_W)) u_detect (
        .bipolar (bipolar),
        .ofs_val (ofs_val),
        .pos_coef(pos_coef),
        .neg_coef(neg_coef),
        .over    (over_c),
        .under   (under_c)
    );

    rc_code_fmt #(.CAL_W(CAL_W), .DATA_W(DATA_W)) u_fmt (
        .fmt     (fmt),
        .over    (over_c),
        .under   (under_c),
        .gain_val(gain_val),
        .word    (word_c)
    );

    // next state: S_IDLE --in_valid--> S_EMIT; S_EMIT --!in_valid--> S_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_valid) state_d = S_EMIT;
            S_EMIT:  if (!in_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_out   <= '0;
            over_flag  <= 1'b0;
            under_flag <= 1'b0;
        end else if (in_valid) begin
            code_out   <= word_c;
            over_flag  <= over_c;
            under_flag <= under_c;
        end
    end

    assign out_valid = (state_q == S_EMIT);
endmodule

// File: rtl/rc_range_coder_chk.sv
module rc_range_coder_chk #(
    parameter int CAL_W  = 28,
    parameter int DATA_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    bipolar,
    input logic                    twos_sel,
    input logic signed [CAL_W-1:0] ofs_val,
    input logic signed [CAL_W-1:0] pos_coef,
    input logic signed [CAL_W-1:0] neg_coef,
    input logic [DATA_W-1:0]       code_out,
    input logic                    over_flag,
    input logic                    under_flag,
    input logic                    out_valid
);
    a_r1_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ofs_val > pos_coef) |=> over_flag);
    a_r2_uni_under: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bipolar) |=> (under_flag == $past(ofs_val[CAL_W-1])));
    a_r3_bip_under: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bipolar && ofs_val < neg_coef) |=> under_flag);
    a_r8_over_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ofs_val > pos_coef && bipolar && twos_sel)
        |=> (code_out == {1'b0, {(DATA_W-1){1'b1}}}));
    a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(code_out) && $stable(over_flag)));
endmodule

bind rc_range_coder rc_range_coder_chk #(.CAL_W(CAL_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bipolar   (bipolar),
    .twos_sel  (twos_sel),
    .ofs_val   (ofs_val),
    .pos_coef  (pos_coef),
    .neg_coef  (neg_coef),
    .code_out  (code_out),
    .over_flag (over_flag),
    .under_flag(under_flag),
    .out_valid (out_valid)
);

// File: tb/rc_range_coder_tb.sv
module rc_range_coder_tb;
    localparam int CAL_W  = 28;
    localparam int DATA_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic bipolar = 1'b1;
    logic twos_sel = 1'b1;
    logic signed [CAL_W-1:0] ofs_val = '0;
    logic signed [CAL_W-1:0] gain_val = '0;
    logic signed [CAL_W-1:0] pos_coef = 28'sd6291456;
    logic signed [CAL_W-1:0] neg_coef = -28'sd6291456;
    logic [DATA_W-1:0] code_out;
    logic over_flag, under_flag, out_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rc_range_coder #(.CAL_W(CAL_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bipolar(bipolar),
        .twos_sel(twos_sel), .ofs_val(ofs_val), .gain_val(gain_val),
        .pos_coef(pos_coef), .neg_coef(neg_coef), .code_out(code_out),
        .over_flag(over_flag), .under_flag(under_flag), .out_valid(out_valid)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // One sample: drive on a falling edge, read results one cycle later.
    task automatic run(input logic bip, input logic tc,
                       input logic signed [CAL_W-1:0] ofs,
                       input logic signed [CAL_W-1:0] gn,
                       input string tag, input logic [DATA_W-1:0] exp_code,
                       input logic exp_over, input logic exp_under);
        @(negedge clk);
        bipolar = bip; twos_sel = tc; ofs_val = ofs; gain_val = gn; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " code"}, 32'(code_out), 32'(exp_code));
        check({tag, " over"}, 32'(over_flag), 32'(exp_over));
        check({tag, " under"}, 32'(under_flag), 32'(exp_under));
        check({tag, " R10 valid"}, 32'(out_valid), 32'd1);
    endtask

    task automatic t_reset;
        check("R11 valid", 32'(out_valid), 0);
        check("R11 code", 32'(code_out), 0);
        check("R11 over", 32'(over_flag), 0);
        check("R11 under", 32'(under_flag), 0);
    endtask

    task automatic t_bipolar_codes;
        run(1, 1, 100, 28'sh123456, "R5 pos", 24'h123456, 0, 0);
        run(1, 1, -100, -28'sd5, "R5 neg", 24'hFFFFFB, 0, 0);
        run(1, 0, 100, 28'sh123456, "R6 pos", 24'h923456, 0, 0);
        run(1, 0, -100, -28'sd5, "R6 neg", 24'h7FFFFB, 0, 0);
    endtask

    task automatic t_unipolar_codes;
        run(0, 1, 100, 28'shABCDEF, "R7 tc1", 24'hABCDEF, 0, 0);
        run(0, 0, 100, 28'shABCDEF, "R7 tc0", 24'hABCDEF, 0, 0);
    endtask

    task automatic t_over;
        run(1, 1, 28'sd6291457, 28'sd10, "R1 R8 bip tc", 24'h7FFFFF, 1, 0);
        run(1, 0, 28'sd6291457, 28'sd10, "R1 R8 bip ob", 24'hFFFFFF, 1, 0);
        run(0, 1, 28'sd6291457, 28'sd10, "R1 R8 uni", 24'hFFFFFF, 1, 0);
        run(1, 1, 28'sd6291456, 28'sh400000, "R1 equal", 24'h400000, 0, 0);
    endtask

    task automatic t_under;
        run(1, 1, -28'sd6291457, 28'sd10, "R3 R8 bip tc", 24'h800000, 0, 1);
        run(1, 0, -28'sd6291457, 28'sd10, "R3 R8 bip ob", 24'h000000, 0, 1);
        run(1, 1, -28'sd6291456, -28'sd7, "R3 equal", 24'hFFFFF9, 0, 0);
        run(0, 1, -28'sd1, 28'sd10, "R2 uni neg", 24'h000000, 0, 1);
        run(0, 1, 28'sd0, 28'sd10, "R2 uni zero", 24'h00000A, 0, 0);
    endtask

    task automatic t_flag_source;
        run(1, 1, 28'sd50, 28'sh7000000 - 1, "R4 big gain", 24'h7FFFFF, 0, 0);
        run(1, 1, 28'sd7000000, 28'sd3, "R4 small gain", 24'h7FFFFF, 1, 0);
        // both flags: unipolar with negative sample above a negative endpoint
        pos_coef = -28'sd10;
        run(0, 1, -28'sd5, 28'sd3, "R8 both", 24'hFFFFFF, 1, 1);
        pos_coef = 28'sd6291456;
    endtask

    task automatic t_saturate;
        run(1, 1, 28'sd10, 28'sh900000, "R9 bip hi", 24'h7FFFFF, 0, 0);
        run(1, 1, -28'sd10, -28'sh900000, "R9 bip lo", 24'h800000, 0, 0);
        run(1, 0, 28'sd10, 28'sh900000, "R9 ob hi", 24'hFFFFFF, 0, 0);
        run(0, 1, 28'sd10, 28'sh1000000, "R9 uni hi", 24'hFFFFFF, 0, 0);
        run(0, 1, 28'sd10, -28'sd2, "R9 uni lo", 24'h000000, 0, 0);
    endtask

    task automatic t_hold;
        run(1, 1, 100, 28'sh012345, "R10 load", 24'h012345, 0, 0);
        @(negedge clk);
        gain_val = 28'sh054321;
        ofs_val = 28'sd7000000;
        @(negedge clk);
        check("R10 drop", 32'(out_valid), 0);
        check("R10 hold code", 32'(code_out), 32'h012345);
        check("R10 hold over", 32'(over_flag), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bipolar_codes();
        t_unipolar_codes();
        t_over();
        t_under();
        t_flag_source();
        t_saturate();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule